// File: doc/BRIEF.md
# Safeload Parameter Update Engine

This block stages a small batch of coefficient updates and writes them into the running signal processor's storage without disturbing audio. A control port fills numbered slots. Each slot holds a target address and a data word. Writing a slot's address marks that slot as pending. Writing its data only stores the word and does not mark the slot.

A commit request arms the engine. The engine then waits until the DSP core reports that the RAM is idle. In each idle cycle it takes the lowest-numbered pending slot and turns it into a write on one of two RAM ports.

The stored address picks the destination and its width. A coefficient-RAM address sends the low 28 data bits to the coefficient port. A ramp-target address sends the low 34 bits to the ramp-target port. Any other address, such as instruction memory or control registers, is dropped without a write. Because a whole batch drains in a few idle cycles, a complete filter section changes within one audio frame.

Top module: `safeload_engine`

## Requirements
- R1: After reset `busy`, `pram_we` and `sram_we` are 0 and no slot is pending, so a commit request right after reset leaves `busy` at 0.
- R2: `addr_wr_en` with `addr_wr_idx` below 5 stores `addr_wr_val` in that slot and marks it pending. `data_wr_en` with `data_wr_idx` below 5 stores the 40-bit `data_wr_val` without marking the slot. Writes with index 5 to 7 have no effect.
- R3: A commit request while no slot is pending has no effect: `busy` stays 0.
- R4: A write strobe appears only in the cycle right after a cycle in which both `busy` and `ram_idle` were 1.
- R5: Pending slots are drained in ascending slot order, at most one slot per idle cycle, whatever order they were loaded in.
- R6: The address decides the destination. An address in 0x0000..0x03FF strobes `pram_we` with `pram_addr` = address bits [9:0] and `pram_wdata` = data bits [27:0]. An address in 0x0A00..0x0A3F strobes `sram_we` with `sram_addr` = address bits [5:0] and `sram_wdata` = data bits [33:0]. Any other address uses up its idle cycle and produces no strobe.
- R7: If `ram_idle` falls partway through a batch, draining pauses with no strobe and then resumes at the next pending slot once `ram_idle` returns.
- R8: A commit request with a pending slot raises `busy` on the next edge. `busy` falls on the same edge that outputs the last slot's write, or its skip.
- R9: Slot address and data writes made while `busy` is 1 are ignored.
- R10: `pram_we` and `sram_we` are never 1 in the same cycle.
- R11: A drained slot is no longer pending, so a second commit request without new address writes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr_en | input | 1 | Slot data write strobe |
| data_wr_idx | input | 3 | Slot index for data write |
| data_wr_val | input | 40 | Data word (5 bytes) |
| addr_wr_en | input | 1 | Slot address write strobe; marks slot pending |
| addr_wr_idx | input | 3 | Slot index for address write |
| addr_wr_val | input | 16 | Target address (2 bytes) |
| commit_req | input | 1 | Start draining the pending slots |
| ram_idle | input | 1 | DSP core is not accessing the RAM this cycle |
| busy | output | 1 | Batch armed and not yet fully drained |
| pram_we | output | 1 | Coefficient RAM write strobe |
| pram_addr | output | 10 | Coefficient RAM write address |
| pram_wdata | output | 28 | Coefficient RAM write data |
| sram_we | output | 1 | Ramp-target RAM write strobe |
| sram_addr | output | 6 | Ramp-target RAM write address |
| sram_wdata | output | 34 | Ramp-target RAM write data |

## Verification
Wrong pending state shows up at the ports. A slot that stays pending after being drained keeps `busy` high one cycle too long and repeats its strobe. A slot that gets lost drops `busy` early and leaves a strobe missing. Either fault is visible at the first idle cycle after the commit. Errors in the priority or the decode show as a wrong address or data on the strobe in that same cycle. A lock that fails during `busy` shows as an extra or altered write in the batch that is draining, or in the next one.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef enum logic [1:0] {
    DST_NONE  = 2'd0,
    DST_PARAM = 2'd1,
    DST_SLEW  = 2'd2
  } sl_dest_e;

  // Classify an address against two windows given as base and depth.
  // The unsigned offset wraps for addresses below a base, so one compare
  // covers both ends of each window.
  function automatic sl_dest_e sl_classify(input int unsigned addr,
                                           input int unsigned p_base,
                                           input int unsigned p_depth,
                                           input int unsigned s_base,
                                           input int unsigned s_depth);
    int unsigned p_off;
    int unsigned s_off;
    p_off = addr - p_base;
    s_off = addr - s_base;
    if (p_off < p_depth) return DST_PARAM;
    if (s_off < s_depth) return DST_SLEW;
    return DST_NONE;
  endfunction

endpackage

// File: rtl/sl_slot_bank.sv
module sl_slot_bank #(
  parameter int NUM_SLOTS = 5,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 40
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              lock,
  input  logic                              data_wr_en,
  input  logic [IDX_W-1:0]                  data_wr_idx,
  input  logic [DATA_W-1:0]                 data_wr_val,
  input  logic                              addr_wr_en,
  input  logic [IDX_W-1:0]                  addr_wr_idx,
  input  logic [ADDR_W-1:0]                 addr_wr_val,
  input  logic [NUM_SLOTS-1:0]              clr_mask,
  output logic [NUM_SLOTS-1:0]              valid,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_data
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_addr;
    logic hit_data;
    assign hit_addr = addr_wr_en && !lock && (addr_wr_idx == IDX_W'(g));
    assign hit_data = data_wr_en && !lock && (data_wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[g]     <= 1'b0;
        slot_addr[g] <= '0;
        slot_data[g] <= '0;
      end else begin
        if (hit_addr) begin
          slot_addr[g] <= addr_wr_val;
          valid[g]     <= 1'b1;
        end else if (clr_mask[g]) begin
          valid[g]     <= 1'b0;
        end
        if (hit_data) slot_data[g] <= data_wr_val;
      end
    end
  end

endmodule

// File: rtl/sl_picker.sv
module sl_picker #(
  parameter int NUM_SLOTS = 5,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 any,
  output logic                 last,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_SLOTS-1:0] onehot
);

  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (req[i] && !any) begin
        any       = 1'b1;
        idx       = IDX_W'(i);
        onehot[i] = 1'b1;
      end
    end
    last = any && ((req & ~onehot) == '0);
  end

endmodule

// File: rtl/sl_commit_ctrl.sv
module sl_commit_ctrl
  import sl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 40,
  parameter int P_AW     = 10,
  parameter int P_DW     = 28,
  parameter int S_AW     = 6,
  parameter int S_DW     = 34,
  parameter int P_BASE   = 0,
  parameter int S_BASE   = 2560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_req,
  input  logic              ram_idle,
  input  logic              any_valid,
  input  logic              pick_last,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_data,
  output logic              armed,
  output logic              grant_v,
  output logic              pram_we,
  output logic [P_AW-1:0]   pram_addr,
  output logic [P_DW-1:0]   pram_wdata,
  output logic              sram_we,
  output logic [S_AW-1:0]   sram_addr,
  output logic [S_DW-1:0]   sram_wdata
);

  localparam int P_DEPTH = 1 << P_AW;
  localparam int S_DEPTH = 1 << S_AW;

  sl_dest_e dest;

  assign grant_v = armed && ram_idle && any_valid;
  assign dest    = sl_classify(32'(sel_addr), P_BASE, P_DEPTH, S_BASE, S_DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (!armed) begin
      if (commit_req && any_valid) armed <= 1'b1;
    end else if (grant_v && pick_last) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pram_we    <= 1'b0;
      sram_we    <= 1'b0;
      pram_addr  <= '0;
      pram_wdata <= '0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      pram_we <= grant_v && (dest == DST_PARAM);
      sram_we <= grant_v && (dest == DST_SLEW);
      if (grant_v && dest == DST_PARAM) begin
        pram_addr  <= sel_addr[P_AW-1:0];
        pram_wdata <= sel_data[P_DW-1:0];
      end
      if (grant_v && dest == DST_SLEW) begin
        sram_addr  <= sel_addr[S_AW-1:0];
        sram_wdata <= sel_data[S_DW-1:0];
      end
    end
  end

endmodule

// File: rtl/safeload_engine.sv
module safeload_engine #(
  parameter int NUM_SLOTS = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 40,
  parameter int P_AW      = 10,
  parameter int P_DW      = 28,
  parameter int S_AW      = 6,
  parameter int S_DW      = 34,
  parameter int P_BASE    = 0,
  parameter int S_BASE    = 2560,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr_en,
  input  logic [IDX_W-1:0]  data_wr_idx,
  input  logic [DATA_W-1:0] data_wr_val,
  input  logic              addr_wr_en,
  input  logic [IDX_W-1:0]  addr_wr_idx,
  input  logic [ADDR_W-1:0] addr_wr_val,
  input  logic              commit_req,
  input  logic              ram_idle,
  output logic              busy,
  output logic              pram_we,
  output logic [P_AW-1:0]   pram_addr,
  output logic [P_DW-1:0]   pram_wdata,
  output logic              sram_we,
  output logic [S_AW-1:0]   sram_addr,
  output logic [S_DW-1:0]   sram_wdata
);

  // Named internal events, brought out for the checker.
  logic [NUM_SLOTS-1:0]             slot_valid;
  logic [NUM_SLOTS-1:0]             grant_oh;
  logic [IDX_W-1:0]                 grant_idx;
  logic                             grant_v;
  logic                             pick_any;
  logic                             pick_last;
  logic [NUM_SLOTS-1:0]             clr_mask;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
  logic [ADDR_W-1:0]                sel_addr;
  logic [DATA_W-1:0]                sel_data;

  assign clr_mask = grant_v ? grant_oh : '0;

  sl_slot_bank #(
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .lock(busy),
    .data_wr_en(data_wr_en), .data_wr_idx(data_wr_idx), .data_wr_val(data_wr_val),
    .addr_wr_en(addr_wr_en), .addr_wr_idx(addr_wr_idx), .addr_wr_val(addr_wr_val),
    .clr_mask(clr_mask), .valid(slot_valid),
    .slot_addr(slot_addr), .slot_data(slot_data)
  );

  sl_picker #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .req(slot_valid), .any(pick_any), .last(pick_last),
    .idx(grant_idx), .onehot(grant_oh)
  );

  // One-hot AND-OR select of the granted slot.
  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel_addr = sel_addr | (slot_addr[i] & {ADDR_W{grant_oh[i]}});
      sel_data = sel_data | (slot_data[i] & {DATA_W{grant_oh[i]}});
    end
  end

  sl_commit_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .P_AW(P_AW), .P_DW(P_DW),
    .S_AW(S_AW), .S_DW(S_DW), .P_BASE(P_BASE), .S_BASE(S_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .ram_idle(ram_idle),
    .any_valid(pick_any), .pick_last(pick_last),
    .sel_addr(sel_addr), .sel_data(sel_data),
    .armed(busy), .grant_v(grant_v),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

endmodule

// File: rtl/sl_checker.sv
module sl_checker #(
  parameter int NUM_SLOTS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 commit_req,
  input logic                 ram_idle,
  input logic                 busy,
  input logic                 pram_we,
  input logic                 sram_we,
  input logic                 grant_v,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic [NUM_SLOTS-1:0] grant_oh
);

  // R10
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(pram_we && sram_we));

  // R4
  a_r4_strobe_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pram_we || sram_we) |-> $past(ram_idle && busy));

  // R3
  a_r3_empty_commit_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit_req && slot_valid == '0) |=> !busy);

  // R8
  a_r8_busy_falls_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (slot_valid == '0));

  // R11
  a_r11_granted_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    grant_v |=> ((slot_valid & $past(grant_oh)) == '0));

  // R9
  a_r9_no_new_pending_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((slot_valid & ~$past(slot_valid)) == '0));

  // R5
  a_r5_one_slot_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_v |-> $onehot0(grant_oh));

endmodule

bind safeload_engine sl_checker #(.NUM_SLOTS(NUM_SLOTS)) u_sl_chk (
  .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .ram_idle(ram_idle),
  .busy(busy), .pram_we(pram_we), .sram_we(sram_we), .grant_v(grant_v),
  .slot_valid(slot_valid), .grant_oh(grant_oh)
);

// File: tb/tb_safeload_engine.sv
module tb_safeload_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        data_wr_en;
  logic [2:0]  data_wr_idx;
  logic [39:0] data_wr_val;
  logic        addr_wr_en;
  logic [2:0]  addr_wr_idx;
  logic [15:0] addr_wr_val;
  logic        commit_req;
  logic        ram_idle;
  logic        busy;
  logic        pram_we;
  logic [9:0]  pram_addr;
  logic [27:0] pram_wdata;
  logic        sram_we;
  logic [5:0]  sram_addr;
  logic [33:0] sram_wdata;

  always #2.5 clk = ~clk;

  safeload_engine dut (
    .clk(clk), .rst_n(rst_n),
    .data_wr_en(data_wr_en), .data_wr_idx(data_wr_idx), .data_wr_val(data_wr_val),
    .addr_wr_en(addr_wr_en), .addr_wr_idx(addr_wr_idx), .addr_wr_val(addr_wr_val),
    .commit_req(commit_req), .ram_idle(ram_idle), .busy(busy),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // Bench model of the requirements.
  logic        m_armed;
  logic [4:0]  m_valid;
  logic [15:0] m_addr [5];
  logic [39:0] m_data [5];
  logic        e_pwe, e_swe;
  logic [9:0]  e_paddr;
  logic [27:0] e_pdata;
  logic [5:0]  e_saddr;
  logic [33:0] e_sdata;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic int first_pending(input logic [4:0] v);
    for (int i = 4; i >= 0; i--) if (v[i]) first_pending = i;
  endfunction

  task automatic model_edge();
    logic       pre_armed;
    logic [4:0] pre_valid;
    int         k;
    pre_armed = m_armed;
    pre_valid = m_valid;
    e_pwe = 1'b0;
    e_swe = 1'b0;
    if (!rst_n) begin
      m_armed = 1'b0;
      m_valid = '0;
      return;
    end
    if (pre_armed && ram_idle && pre_valid != 0) begin
      k = first_pending(pre_valid);
      if (m_addr[k] <= 16'h03FF) begin
        e_pwe = 1'b1; e_paddr = m_addr[k][9:0]; e_pdata = m_data[k][27:0];
      end else if (m_addr[k] >= 16'h0A00 && m_addr[k] <= 16'h0A3F) begin
        e_swe = 1'b1; e_saddr = m_addr[k][5:0]; e_sdata = m_data[k][33:0];
      end
      m_valid[k] = 1'b0;
      if (m_valid == 0) m_armed = 1'b0;
    end else if (!pre_armed && commit_req && pre_valid != 0) begin
      m_armed = 1'b1;
    end
    if (!pre_armed) begin
      if (addr_wr_en && addr_wr_idx < 5) begin
        m_addr[addr_wr_idx]  = addr_wr_val;
        m_valid[addr_wr_idx] = 1'b1;
      end
      if (data_wr_en && data_wr_idx < 5) m_data[data_wr_idx] = data_wr_val;
    end
  endtask

  task automatic compare_outputs();
    chk("busy", 64'(busy), 64'(m_armed));
    chk("pram_we", 64'(pram_we), 64'(e_pwe));
    chk("sram_we", 64'(sram_we), 64'(e_swe));
    chk("R10 strobe overlap", 64'(pram_we && sram_we), 64'd0);
    if (e_pwe) begin
      chk("pram_addr", 64'(pram_addr), 64'(e_paddr));
      chk("pram_wdata", 64'(pram_wdata), 64'(e_pdata));
    end
    if (e_swe) begin
      chk("sram_addr", 64'(sram_addr), 64'(e_saddr));
      chk("sram_wdata", 64'(sram_wdata), 64'(e_sdata));
    end
  endtask

  // One clock: inputs already set; model follows the edge; compare away from it.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_outputs();
    data_wr_en = 1'b0;
    addr_wr_en = 1'b0;
    commit_req = 1'b0;
  endtask

  task automatic load(input int idx, input logic [15:0] a, input logic [39:0] d);
    data_wr_en = 1'b1; data_wr_idx = 3'(idx); data_wr_val = d;
    addr_wr_en = 1'b1; addr_wr_idx = 3'(idx); addr_wr_val = a;
    step();
  endtask

  task automatic commit_and_drain(input int idle_gap);
    commit_req = 1'b1;
    step();
    for (int i = 0; i < 20; i++) begin
      ram_idle = (idle_gap == 0) ? 1'b1 : ((i % (idle_gap + 1)) == idle_gap);
      step();
    end
    ram_idle = 1'b1;
  endtask

  function automatic logic [39:0] rnd40();
    return 40'({$urandom(), $urandom()});
  endfunction

  function automatic logic [15:0] rnd_addr();
    case ($urandom % 4)
      0: return 16'($urandom % 1024);
      1: return 16'h0A00 + 16'($urandom % 64);
      2: return 16'h0400 + 16'($urandom % 1536);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; data_wr_en = 0; data_wr_idx = 0; data_wr_val = 0;
    addr_wr_en = 0; addr_wr_idx = 0; addr_wr_val = 0; commit_req = 0; ram_idle = 1;
    m_armed = 0; m_valid = 0; e_pwe = 0; e_swe = 0;
    e_paddr = 0; e_pdata = 0; e_saddr = 0; e_sdata = 0;
    for (int i = 0; i < 5; i++) begin m_addr[i] = 0; m_data[i] = 0; end
    repeat (3) step();
    rst_n = 1'b1;

    // R1: reset state, then a commit straight after reset
    cur_req = "R1";
    step();
    commit_req = 1'b1; step(); step();

    // R3: commit with nothing pending
    cur_req = "R3";
    data_wr_en = 1; data_wr_idx = 3'd2; data_wr_val = rnd40(); step();
    commit_req = 1'b1; step(); step();

    // R2: out-of-range indices ignored; data-only write never pends
    cur_req = "R2";
    for (int i = 5; i < 8; i++) load(i, 16'h0010, rnd40());
    commit_req = 1'b1; step(); step();
    chk("R2 busy after ignored writes", 64'(busy), 64'd0);

    // R6: all decode boundaries and a skipped address
    cur_req = "R6";
    load(0, 16'h0000, rnd40());
    load(1, 16'h03FF, rnd40());
    load(2, 16'h0A00, rnd40());
    load(3, 16'h0A3F, rnd40());
    load(4, 16'h0400, rnd40());
    commit_and_drain(0);
    load(0, 16'h0A40, rnd40());
    load(1, 16'h09FF, rnd40());
    load(2, 16'hFFFF, rnd40());
    load(3, 16'h0200, 40'hFF_FFFF_FFFF);
    commit_and_drain(0);

    // R5: loaded in reverse order, drained ascending
    cur_req = "R5";
    for (int i = 4; i >= 0; i--) load(i, 16'(i * 7), rnd40());
    commit_and_drain(0);

    // R4: commit while the RAM stays busy for a while
    cur_req = "R4";
    load(1, 16'h0A05, rnd40());
    ram_idle = 0; commit_req = 1; step();
    for (int i = 0; i < 6; i++) step();
    ram_idle = 1; step(); step();

    // R7: idle drops partway through a batch
    cur_req = "R7";
    for (int i = 0; i < 5; i++) load(i, 16'h0100 + 16'(i), rnd40());
    commit_and_drain(2);

    // R9: writes during busy are ignored; R11: second commit inert
    cur_req = "R9";
    load(0, 16'h0011, rnd40());
    ram_idle = 0; commit_req = 1; step();
    load(0, 16'h0A22, rnd40());
    load(3, 16'h0033, rnd40());
    ram_idle = 1; step(); step(); step();
    cur_req = "R11";
    commit_req = 1; step(); step();
    chk("R11 busy after re-commit", 64'(busy), 64'd0);

    // R8: single-slot batch, busy falls with its strobe
    cur_req = "R8";
    load(2, 16'h0A01, rnd40());
    commit_req = 1; step();
    step();
    step();

    // R10: constrained random traffic
    cur_req = "R10";
    for (int c = 0; c < 4000; c++) begin
      addr_wr_en  = ($urandom % 4) == 0;
      addr_wr_idx = 3'($urandom % 8);
      addr_wr_val = rnd_addr();
      data_wr_en  = ($urandom % 3) == 0;
      data_wr_idx = 3'($urandom % 8);
      data_wr_val = rnd40();
      commit_req  = ($urandom % 8) == 0;
      ram_idle    = ($urandom % 4) != 0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule